// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block moves a small system between three power states: Active, Sleep and Deep-sleep. The processor asks for a low-power state by pulsing a wait-for-interrupt strobe. At that edge the block reads a two-bit mode select to decide between Sleep and Deep-sleep. It then drives registered clock-enable levels for the processor, the main/peripheral clock tree and the watchdog. It also drives a power-down vector for the analog blocks, an enable that connects the internal oscillator to the main clock, and a flash standby request.

In Sleep, only the processor clock stops. In Deep-sleep the main clock, the peripheral clocks and every analog block stop, with the exceptions set by a two-bit deep-sleep mask (brown-out detector and watchdog oscillator) and by the watchdog-lock override. The internal oscillator stays powered in Deep-sleep, but its output to the main clock is cut. Any enabled interrupt brings the block back to Active, and the power-down vector then follows the run-time mask again. Deep-sleep is refused unless the main clock already runs from the internal oscillator. An interrupt that is already pending at the strobe cancels entry.

All pins are plain control and status levels. No data flows through the block, so there is no handshake at its edge.

Top module: `pwr_mode_seq`

## Requirements
- R1: While reset is low, mode_o is 0 (Active), every clock enable and irc_out_en_o are 1, flash_stby_o and refused_o are 0, and pd_o equals the PD_RST parameter (default 6'b111000). This holds whatever state the block was in before.
- R2: In Active, mode_o does not change unless wfi_i is high at a clock edge.
- R3: A strobe with mode_sel_i other than 1 and no pending interrupt moves the block to Sleep (mode_o = 1) after that edge. In Sleep, cpu_clk_en_o is 0, sys_clk_en_o, wdt_clk_en_o and irc_out_en_o are 1, flash_stby_o is 0, and pd_o follows run_pd_i.
- R4: A strobe with mode_sel_i = 1, main_src_i = 0 (internal oscillator) and no pending interrupt moves the block to Deep-sleep (mode_o = 2). In Deep-sleep, cpu_clk_en_o, sys_clk_en_o and irc_out_en_o are 0 and flash_stby_o is 1.
- R5: In Deep-sleep, pd_o bit 0 (internal oscillator) is 0. Bit 2 (brown-out detector) equals dslp_pd_i[0] and bit 3 (watchdog oscillator) equals dslp_pd_i[1], both sampled at entry. Every other pd_o bit is 1. A pd_o bit of 1 means powered down.
- R6: In Deep-sleep, wdt_clk_en_o is 1 exactly when either of these held at entry: wdt_src_i = 2 (watchdog oscillator) with dslp_pd_i[1] = 0, or wdt_lock_i = 1 with wdt_src_i = 0 (internal oscillator). The lock case applies regardless of the mask.
- R7: In Sleep or Deep-sleep, a bit set in both irq_i and irq_en_i returns the block to Active after that edge, with all clocks enabled and pd_o equal to run_pd_i. A request whose enable is 0 has no effect.
- R8: If an enabled interrupt is pending at the edge that samples wfi_i, the block stays in Active.
- R9: A Deep-sleep strobe with main_src_i other than 0 (and no pending interrupt) leaves the block in Active and sets refused_o. The flag keeps its value until the next strobe taken in Active, which rewrites it.
- R10: The clock-enable, oscillator-output and flash-standby outputs are registered and change only on an edge where mode_o changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wfi_i | input | 1 | Wait-for-interrupt strobe |
| mode_sel_i | input | 2 | Low-power state select, 1 = Deep-sleep |
| main_src_i | input | 2 | Main clock source, 0 = internal oscillator |
| wdt_src_i | input | 2 | Watchdog clock source: 0 internal osc, 1 main, 2 watchdog osc |
| wdt_lock_i | input | 1 | Watchdog clock source locked |
| dslp_pd_i | input | 2 | Deep-sleep mask: bit0 brown-out off, bit1 watchdog osc off |
| run_pd_i | input | PD_W | Run-time power-down vector |
| irq_i | input | NUM_IRQ | Interrupt requests |
| irq_en_i | input | NUM_IRQ | Interrupt enables |
| mode_o | output | 2 | 0 Active, 1 Sleep, 2 Deep-sleep |
| cpu_clk_en_o | output | 1 | Processor clock enable |
| sys_clk_en_o | output | 1 | Main/peripheral clock enable |
| wdt_clk_en_o | output | 1 | Watchdog clock enable |
| irc_out_en_o | output | 1 | Internal oscillator output to main clock |
| flash_stby_o | output | 1 | Flash standby request |
| pd_o | output | PD_W | Analog power-down controls, 1 = off |
| refused_o | output | 1 | Last Deep-sleep request refused |

## Verification
Every result of a strobe or a wake-up is registered, so it appears one rising edge after the edge that samples wfi_i or the enabled interrupt. Reset acts at once, without waiting for an edge. The bench changes inputs on the falling edge and reads outputs on the next falling edge, which is exactly one register stage later. Stability under ignored requests is checked over several of those half-period-offset samples.

// File: rtl/pms_pkg.sv
package pms_pkg;
  localparam int PD_W     = 6;
  localparam int PD_IRC   = 0;
  localparam int PD_BOD   = 2;
  localparam int PD_WDOSC = 3;

  localparam logic [1:0] SRC_IRC   = 2'd0;
  localparam logic [1:0] SRC_WDOSC = 2'd2;
  localparam logic [1:0] SEL_DEEP  = 2'd1;

  typedef enum logic [1:0] {
    PM_ACTIVE = 2'd0,
    PM_SLEEP  = 2'd1,
    PM_DEEP   = 2'd2
  } pm_state_e;

  typedef struct packed {
    logic            cpu_en;
    logic            sys_en;
    logic            wdt_en;
    logic            irc_out_en;
    logic            flash_stby;
    logic [PD_W-1:0] pd;
  } pm_out_t;
endpackage

// File: rtl/pms_wake_detect.sv
module pms_wake_detect #(
  parameter int NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  output logic               wake_o
);
  logic [NUM_IRQ-1:0] hit;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_hit
    assign hit[g] = irq_i[g] & irq_en_i[g];
  end

  assign wake_o = |hit;
endmodule

// File: rtl/pms_deep_cfg.sv
module pms_deep_cfg
  import pms_pkg::*;
(
  input  logic [1:0]      dslp_pd_i,
  input  logic            wdt_lock_i,
  input  logic [1:0]      wdt_src_i,
  output logic [PD_W-1:0] deep_pd_o,
  output logic            deep_wdt_en_o
);
  // Per-bit power-down level while in Deep-sleep.
  for (genvar g = 0; g < PD_W; g++) begin : g_pd
    if (g == PD_IRC) begin : g_irc
      assign deep_pd_o[g] = 1'b0;
    end else if (g == PD_BOD) begin : g_bod
      assign deep_pd_o[g] = dslp_pd_i[0];
    end else if (g == PD_WDOSC) begin : g_wdo
      assign deep_pd_o[g] = dslp_pd_i[1];
    end else begin : g_off
      assign deep_pd_o[g] = 1'b1;
    end
  end

  logic irc_locked;
  logic wdosc_live;

  assign irc_locked    = wdt_lock_i && (wdt_src_i == SRC_IRC);
  assign wdosc_live    = (wdt_src_i == SRC_WDOSC) && !dslp_pd_i[1];
  assign deep_wdt_en_o = irc_locked | wdosc_live;
endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
  import pms_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wfi_i,
  input  logic [1:0] mode_sel_i,
  input  logic [1:0] main_src_i,
  input  logic       wake_i,
  output pm_state_e  state_q_o,
  output pm_state_e  state_d_o,
  output logic       refused_o
);
  pm_state_e state_q, state_d;
  logic      ref_q, ref_d;
  logic      deep_req, clk_ok;

  assign deep_req = (mode_sel_i == SEL_DEEP);
  assign clk_ok   = (main_src_i == SRC_IRC);

  always_comb begin
    state_d = state_q;
    ref_d   = ref_q;
    unique case (state_q)
      PM_ACTIVE: begin
        if (wfi_i) begin
          ref_d = deep_req && !clk_ok && !wake_i;
          if (!wake_i) begin
            if (!deep_req)   state_d = PM_SLEEP;
            else if (clk_ok) state_d = PM_DEEP;
          end
        end
      end
      PM_SLEEP, PM_DEEP: begin
        if (wake_i) state_d = PM_ACTIVE;
      end
      default: state_d = PM_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_ACTIVE;
      ref_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ref_q   <= ref_d;
    end
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;
  assign refused_o = ref_q;

  p_no_entry_without_wfi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_ACTIVE && !wfi_i) |=> (state_q == PM_ACTIVE));

  p_pending_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_ACTIVE && wfi_i && wake_i) |=> (state_q == PM_ACTIVE));

  p_refused_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_ACTIVE && wfi_i && deep_req && !clk_ok && !wake_i)
      |=> (state_q == PM_ACTIVE && ref_q));

  p_wake_returns_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PM_ACTIVE && wake_i) |=> (state_q == PM_ACTIVE));
endmodule

// File: rtl/pms_out_reg.sv
module pms_out_reg
  import pms_pkg::*;
#(
  parameter logic [PD_W-1:0] PD_RST = 6'b111000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pm_state_e       state_q_i,
  input  pm_state_e       state_d_i,
  input  logic [PD_W-1:0] run_pd_i,
  input  logic [PD_W-1:0] deep_pd_i,
  input  logic            deep_wdt_en_i,
  output pm_out_t         out_o
);
  pm_out_t out_q, out_d;

  always_comb begin
    out_d = out_q;
    unique case (state_d_i)
      PM_ACTIVE: begin
        out_d = '{cpu_en: 1'b1, sys_en: 1'b1, wdt_en: 1'b1, irc_out_en: 1'b1,
                  flash_stby: 1'b0, pd: run_pd_i};
      end
      PM_SLEEP: begin
        out_d = '{cpu_en: 1'b0, sys_en: 1'b1, wdt_en: 1'b1, irc_out_en: 1'b1,
                  flash_stby: 1'b0, pd: run_pd_i};
      end
      PM_DEEP: begin
        // Configuration is captured on the entry edge only and held after.
        if (state_q_i != PM_DEEP) begin
          out_d = '{cpu_en: 1'b0, sys_en: 1'b0, wdt_en: deep_wdt_en_i,
                    irc_out_en: 1'b0, flash_stby: 1'b1, pd: deep_pd_i};
        end
      end
      default: out_d = out_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '{cpu_en: 1'b1, sys_en: 1'b1, wdt_en: 1'b1, irc_out_en: 1'b1,
                 flash_stby: 1'b0, pd: PD_RST};
    end else begin
      out_q <= out_d;
    end
  end

  assign out_o = out_q;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_sleep_gates_cpu_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q_i == PM_SLEEP) |-> (!out_q.cpu_en && out_q.sys_en && out_q.wdt_en
                                 && out_q.irc_out_en && !out_q.flash_stby));

  p_deep_gates_main_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q_i == PM_DEEP) |-> (!out_q.cpu_en && !out_q.sys_en
                                && !out_q.irc_out_en && out_q.flash_stby));

  p_deep_irc_powered_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q_i == PM_DEEP) |-> !out_q.pd[PD_IRC]);

  p_wake_restores_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && state_q_i == PM_ACTIVE && $past(state_q_i) != PM_ACTIVE)
      |-> (out_q.pd == $past(run_pd_i) && out_q.cpu_en && out_q.sys_en));

  p_enables_follow_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && state_q_i == $past(state_q_i))
      |-> ($stable(out_q.cpu_en) && $stable(out_q.sys_en) && $stable(out_q.wdt_en)
           && $stable(out_q.irc_out_en) && $stable(out_q.flash_stby)));
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int               NUM_IRQ = 8,
  parameter logic [PD_W-1:0]  PD_RST  = 6'b111000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wfi_i,
  input  logic [1:0]         mode_sel_i,
  input  logic [1:0]         main_src_i,
  input  logic [1:0]         wdt_src_i,
  input  logic               wdt_lock_i,
  input  logic [1:0]         dslp_pd_i,
  input  logic [PD_W-1:0]    run_pd_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  output logic [1:0]         mode_o,
  output logic               cpu_clk_en_o,
  output logic               sys_clk_en_o,
  output logic               wdt_clk_en_o,
  output logic               irc_out_en_o,
  output logic               flash_stby_o,
  output logic [PD_W-1:0]    pd_o,
  output logic               refused_o
);
  logic            wake;
  pm_state_e       st_q, st_d;
  logic [PD_W-1:0] deep_pd;
  logic            deep_wdt_en;
  pm_out_t         outs;

  pms_wake_detect #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .irq_i    (irq_i),
    .irq_en_i (irq_en_i),
    .wake_o   (wake)
  );

  pms_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wfi_i      (wfi_i),
    .mode_sel_i (mode_sel_i),
    .main_src_i (main_src_i),
    .wake_i     (wake),
    .state_q_o  (st_q),
    .state_d_o  (st_d),
    .refused_o  (refused_o)
  );

  pms_deep_cfg u_deep (
    .dslp_pd_i     (dslp_pd_i),
    .wdt_lock_i    (wdt_lock_i),
    .wdt_src_i     (wdt_src_i),
    .deep_pd_o     (deep_pd),
    .deep_wdt_en_o (deep_wdt_en)
  );

  pms_out_reg #(.PD_RST(PD_RST)) u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .state_q_i     (st_q),
    .state_d_i     (st_d),
    .run_pd_i      (run_pd_i),
    .deep_pd_i     (deep_pd),
    .deep_wdt_en_i (deep_wdt_en),
    .out_o         (outs)
  );

  assign mode_o       = st_q;
  assign cpu_clk_en_o = outs.cpu_en;
  assign sys_clk_en_o = outs.sys_en;
  assign wdt_clk_en_o = outs.wdt_en;
  assign irc_out_en_o = outs.irc_out_en;
  assign flash_stby_o = outs.flash_stby;
  assign pd_o         = outs.pd;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_deep_mask_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && mode_o == PM_DEEP && $past(mode_o) != PM_DEEP)
      |-> (pd_o[PD_BOD] == $past(dslp_pd_i[0]) && pd_o[PD_WDOSC] == $past(dslp_pd_i[1])));

  p_locked_irc_clocks_wdt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && mode_o == PM_DEEP && $past(mode_o) != PM_DEEP
     && $past(wdt_lock_i) && $past(wdt_src_i) == SRC_IRC) |-> wdt_clk_en_o);
endmodule

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wfi_i = 1'b0;
  logic [1:0] mode_sel_i = 2'd0, main_src_i = 2'd0, wdt_src_i = 2'd0, dslp_pd_i = 2'd0;
  logic       wdt_lock_i = 1'b0;
  logic [5:0] run_pd_i = 6'b110000;
  logic [7:0] irq_i = 8'd0, irq_en_i = 8'd0;
  logic [1:0] mode_o;
  logic       cpu_clk_en_o, sys_clk_en_o, wdt_clk_en_o, irc_out_en_o, flash_stby_o, refused_o;
  logic [5:0] pd_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  pwr_mode_seq i_pwr_mode_seq (
    .clk(clk), .rst_n(rst_n), .wfi_i(wfi_i), .mode_sel_i(mode_sel_i),
    .main_src_i(main_src_i), .wdt_src_i(wdt_src_i), .wdt_lock_i(wdt_lock_i),
    .dslp_pd_i(dslp_pd_i), .run_pd_i(run_pd_i), .irq_i(irq_i), .irq_en_i(irq_en_i),
    .mode_o(mode_o), .cpu_clk_en_o(cpu_clk_en_o), .sys_clk_en_o(sys_clk_en_o),
    .wdt_clk_en_o(wdt_clk_en_o), .irc_out_en_o(irc_out_en_o),
    .flash_stby_o(flash_stby_o), .pd_o(pd_o), .refused_o(refused_o)
  );

  typedef struct packed {
    logic [1:0] sel; logic [1:0] msrc; logic [1:0] wsrc; logic lock;
    logic [1:0] dcfg; logic pend;
    logic [1:0] xmode; logic xwdt; logic [5:0] xpd; logic xref;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd0, 2'd0, 1'b0, 2'b11, 1'b0, 2'd1, 1'b1, 6'b110000, 1'b0},
    '{2'd2, 2'd1, 2'd0, 1'b0, 2'b11, 1'b0, 2'd1, 1'b1, 6'b110000, 1'b0},
    '{2'd1, 2'd0, 2'd2, 1'b0, 2'b01, 1'b0, 2'd2, 1'b1, 6'b110110, 1'b0},
    '{2'd1, 2'd0, 2'd2, 1'b0, 2'b10, 1'b0, 2'd2, 1'b0, 6'b111010, 1'b0},
    '{2'd1, 2'd0, 2'd0, 1'b1, 2'b11, 1'b0, 2'd2, 1'b1, 6'b111110, 1'b0},
    '{2'd1, 2'd0, 2'd0, 1'b0, 2'b11, 1'b0, 2'd2, 1'b0, 6'b111110, 1'b0},
    '{2'd1, 2'd0, 2'd1, 1'b1, 2'b00, 1'b0, 2'd2, 1'b0, 6'b110010, 1'b0},
    '{2'd1, 2'd1, 2'd0, 1'b0, 2'b11, 1'b0, 2'd0, 1'b1, 6'b110000, 1'b1},
    '{2'd0, 2'd0, 2'd0, 1'b0, 2'b11, 1'b1, 2'd0, 1'b1, 6'b110000, 1'b0},
    '{2'd1, 2'd1, 2'd0, 1'b0, 2'b11, 1'b1, 2'd0, 1'b1, 6'b110000, 1'b0}
  };

  function automatic logic [13:0] expect_out(input logic [1:0] m, input logic w,
                                             input logic [5:0] pd, input logic rf);
    return {m, m == 2'd0, m != 2'd2, w, m != 2'd2, m == 2'd2, rf, pd};
  endfunction

  function automatic logic [13:0] seen();
    return {mode_o, cpu_clk_en_o, sys_clk_en_o, wdt_clk_en_o, irc_out_en_o,
            flash_stby_o, refused_o, pd_o};
  endfunction

  task automatic chk(input string tag, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wfi_i = 1'b0; irq_i = '0; irq_en_i = '0;
    step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic strobe();
    wfi_i = 1'b1;
    step();
    wfi_i = 1'b0;
  endtask

  logic [13:0] held;

  initial begin
    // R1: values during reset
    @(negedge clk);
    chk("R1 reset state", seen(), expect_out(2'd0, 1'b1, 6'b111000, 1'b0));
    rst_n = 1'b1;
    step();
    chk("R1 active follows run mask after release", seen(), expect_out(2'd0, 1'b1, 6'b110000, 1'b0));

    // R2: no strobe, Deep-sleep selected, block stays Active
    mode_sel_i = 2'd1;
    for (int i = 0; i < 20; i++) step();
    chk("R2 no entry without strobe", seen(), expect_out(2'd0, 1'b1, 6'b110000, 1'b0));

    // Table walk: R3 R4 R5 R6 R7 R8 R9 R10
    for (int v = 0; v < NV; v++) begin
      do_reset();
      mode_sel_i = VEC[v].sel; main_src_i = VEC[v].msrc; wdt_src_i = VEC[v].wsrc;
      wdt_lock_i = VEC[v].lock; dslp_pd_i = VEC[v].dcfg;
      if (VEC[v].pend) begin irq_i = 8'h04; irq_en_i = 8'h04; end
      strobe();
      irq_i = '0; irq_en_i = '0;
      chk(VEC[v].xmode == 2'd1 ? "R3 sleep entry" :
          VEC[v].xmode == 2'd2 ? "R4 R5 R6 deep entry" :
          VEC[v].pend ? "R8 pending blocks entry" : "R9 deep refused",
          seen(), expect_out(VEC[v].xmode, VEC[v].xwdt, VEC[v].xpd, VEC[v].xref));
      if (VEC[v].xmode != 2'd0) begin
        held = seen();
        // disabled request and live config changes are ignored
        irq_i = 8'h81; irq_en_i = 8'h7E; dslp_pd_i = ~VEC[v].dcfg; wdt_lock_i = ~VEC[v].lock;
        for (int i = 0; i < 3; i++) step();
        chk("R7 R10 disabled irq ignored, outputs held", seen(), held);
        irq_en_i = 8'h01;
        step();
        irq_i = '0; irq_en_i = '0;
        chk("R7 wake to active", seen(), expect_out(2'd0, 1'b1, 6'b110000, 1'b0));
      end
    end

    // R9: refused flag rewritten by next accepted strobe
    do_reset();
    mode_sel_i = 2'd1; main_src_i = 2'd3;
    strobe();
    chk("R9 refused set", seen(), expect_out(2'd0, 1'b1, 6'b110000, 1'b1));
    step(); step();
    chk("R9 refused held", seen(), expect_out(2'd0, 1'b1, 6'b110000, 1'b1));
    mode_sel_i = 2'd0;
    strobe();
    chk("R9 refused cleared by sleep entry", seen(), expect_out(2'd1, 1'b1, 6'b110000, 1'b0));

    // R3 R7: sleep power vector tracks run mask, wake restores it
    run_pd_i = 6'b101010;
    step();
    chk("R3 sleep pd follows run mask", seen(), expect_out(2'd1, 1'b1, 6'b101010, 1'b0));
    irq_i = 8'h10; irq_en_i = 8'h10;
    step();
    irq_i = '0; irq_en_i = '0;
    chk("R7 wake from sleep", seen(), expect_out(2'd0, 1'b1, 6'b101010, 1'b0));
    run_pd_i = 6'b110000;

    // R2: strobe while sleeping is not a new entry
    mode_sel_i = 2'd1; main_src_i = 2'd0; wdt_src_i = 2'd2; dslp_pd_i = 2'b00;
    strobe();
    chk("R4 deep entry", seen(), expect_out(2'd2, 1'b1, 6'b110010, 1'b0));
    strobe();
    chk("R10 strobe in deep ignored", seen(), expect_out(2'd2, 1'b1, 6'b110010, 1'b0));

    // R1: asynchronous reset from Deep-sleep
    #3 rst_n = 1'b0;
    #2;
    chk("R1 reset from deep", seen(), expect_out(2'd0, 1'b1, 6'b111000, 1'b0));
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 50000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule